// File: doc/BRIEF.md
# Shared PLL Vote Aggregator

This block collects enable requests from several clients for one shared PLL and turns them into a single enable register that drives the PLL's vote inputs. Each plain voter owns one bit of that register. Two peer clients, one active-only and one sleep-active, share one soft-vote word. Only the first of them to arrive and the last of them to leave touch their common hardware bit. A separate sleep channel owns one more bit with inverted polarity: enabling it clears the bit, which keeps the PLL running while the processor is powered down, and disabling it sets the bit.

Each client issues a one-cycle request pulse that carries an on/off flag. The request stays pending until the block answers with a one-cycle acknowledge, which may carry an error flag. A single sequencer serves pending requests one at a time, with the lowest client index first. When a vote raises a hardware bit, the sequencer polls the PLL running status. It gives up after a fixed number of poll intervals and reports a timeout. Withdrawals never wait for the status.

At reset the enable register is loaded from a start-up pattern, so clients already voted by earlier software are taken over as enabled.

Top module: `pll_vote_hub`

## Requirements
- R1: During reset the enable register `pll_en` takes the value of `boot_en`. Both bits of `peer_votes` take the value of the shared peer bit `boot_en[N_DIRECT]`. No acknowledge is pending or shown after reset.
- R2: A vote from plain voter i (client index i < N_DIRECT) sets `pll_en[i]`. A withdrawal from that voter clears only `pll_en[i]`. All other bits keep their value in both cases.
- R3: After a vote raises a hardware bit, the block samples `pll_running` on every cycle from the second cycle after the request. With `pll_running` high, the acknowledge arrives two cycles after the request edge and carries no error.
- R4: If `pll_running` stays low for MAX_POLLS*US_CYCLES wait cycles, the vote is acknowledged with `err` set, on cycle 1+MAX_POLLS*US_CYCLES after the request edge. The hardware bit stays set.
- R5: A withdrawal does not wait for the status. It is acknowledged one cycle after the request edge, whatever the level of `pll_running`.
- R6: For a peer vote (client index N_DIRECT for the active-only peer, N_DIRECT+1 for the sleep-active peer), the shared bit `pll_en[N_DIRECT]` is voted only when `peer_votes` is zero. The peer's own `peer_votes` bit is set only when that hardware vote succeeds without a timeout. When `peer_votes` is already non-zero, the peer's bit is set at once, with a one-cycle acknowledge.
- R7: A peer withdrawal clears that peer's `peer_votes` bit first. `pll_en[N_DIRECT]` is cleared in the same cycle only when no peer vote remains.
- R8: The sleep channel (client index N_DIRECT+2) clears `pll_en[N_DIRECT+1]` on enable and sets it on disable. Both are acknowledged one cycle after the request edge with no error, and the bit changes only together with that acknowledge.
- R9: Requests that are pending at the same time are served one at a time, lowest client index first. No vote is lost, and no more than one enable bit changes in any cycle.
- R10: `ack` is a one-cycle pulse with at most one bit high. An `err` bit is high only together with the matching `ack` bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_en | input | N_DIRECT+2 | Start-up image of the enable register, loaded during reset |
| req | input | N_DIRECT+3 | One-cycle request pulse per client |
| req_on | input | N_DIRECT+3 | Per client: 1 = enable (vote), 0 = disable (withdraw), sampled with `req` |
| pll_running | input | 1 | PLL running status |
| pll_en | output | N_DIRECT+2 | Enable register: plain voter bits, the shared peer bit, then the sleep bit |
| peer_votes | output | 2 | Soft-vote word of the peer pair (bit 0 active-only, bit 1 sleep-active) |
| ack | output | N_DIRECT+3 | One-cycle completion pulse per client |
| err | output | N_DIRECT+3 | Timeout flag, valid with `ack` |

## Verification
The hardest case to reach is a peer whose hardware vote timed out. In that state the shared bit is set while the soft-vote word is still zero, so the next peer must vote the hardware again rather than take the fast path. The bench gets there by holding `pll_running` low for one peer vote and then raising it before the other peer's vote. The start-up takeover of peer votes is reached by sweeping every `boot_en` pattern through reset and then withdrawing both peers in turn. Concurrent service order is forced by pulsing several clients' requests on the same edge.

// File: rtl/pll_vote_pkg.sv
// Shared types for the PLL vote aggregator.
// Assumes: nothing beyond IEEE 1800-2017.
package pll_vote_pkg;

    // Sequencer state: idle (arbitrating) or waiting for the PLL status.
    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_t;

    // Client class, decided by the client index.
    typedef enum logic [1:0] {
        CK_DIRECT = 2'd0,
        CK_PEER   = 2'd1,
        CK_SLEEP  = 2'd2
    } client_kind_t;

    // Class of client idx when n_direct plain voters come first.
    function automatic client_kind_t kind_of(input int idx, input int n_direct);
        if (idx < n_direct)
            return CK_DIRECT;
        else if (idx < n_direct + 2)
            return CK_PEER;
        else
            return CK_SLEEP;
    endfunction

endpackage

// File: rtl/pll_vote_intake.sv
// Request intake: holds one pending request, with its on/off flag, per client.
// Assumes: a client pulses req only while it has nothing pending; a pulse
// that arrives while a request is pending is ignored. clr is one-hot or zero.
module pll_vote_intake #(
    parameter int NCLI = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCLI-1:0] req,
    input  logic [NCLI-1:0] req_on,
    input  logic [NCLI-1:0] clr,
    output logic [NCLI-1:0] pending,
    output logic [NCLI-1:0] want_on
);

    genvar gi;
    generate
        for (gi = 0; gi < NCLI; gi++) begin : g_slot
            // Capture a new request, or release the slot when it is served.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pending[gi] <= 1'b0;
                    want_on[gi] <= 1'b0;
                end else if (req[gi] && !pending[gi]) begin
                    pending[gi] <= 1'b1;
                    want_on[gi] <= req_on[gi];
                end else if (clr[gi]) begin
                    pending[gi] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/pll_vote_arb.sv
// Fixed-priority arbiter: picks the lowest-index pending client.
// Assumes: purely combinational; the caller registers the choice.
module pll_vote_arb #(
    parameter int NCLI  = 6,
    parameter int IDX_W = (NCLI > 1) ? $clog2(NCLI) : 1
) (
    input  logic [NCLI-1:0]  pending,
    output logic             any,
    output logic [IDX_W-1:0] grant_idx
);

    // Scan from the top down, so that the lowest pending index wins.
    always_comb begin
        grant_idx = '0;
        for (int i = NCLI - 1; i >= 0; i--) begin
            if (pending[i])
                grant_idx = IDX_W'(i);
        end
        any = |pending;
    end

endmodule

// File: rtl/pll_vote_timer.sv
// Lock-wait timer: counts poll intervals of US_CYCLES clocks and flags the
// last cycle of the MAX_POLLS-th interval.
// Assumes: start clears the count; run is high on every wait cycle.
module pll_vote_timer #(
    parameter int US_CYCLES = 8,
    parameter int MAX_POLLS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic expired
);

    localparam int SUB_W  = (US_CYCLES > 1) ? $clog2(US_CYCLES) : 1;
    localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
    localparam logic [SUB_W-1:0]  SUB_LAST  = SUB_W'(US_CYCLES - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(MAX_POLLS - 1);

    logic [SUB_W-1:0]  sub_q;
    logic [POLL_W-1:0] poll_q;

    // Advance the in-interval count and the interval count while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            sub_q  <= '0;
            poll_q <= '0;
        end else if (run) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                if (poll_q != POLL_LAST)
                    poll_q <= poll_q + 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    // Last wait cycle of the final poll interval.
    always_comb expired = run && (sub_q == SUB_LAST) && (poll_q == POLL_LAST);

endmodule

// File: rtl/pll_vote_hub.sv
// Shared PLL vote aggregator: serialises client votes into one enable
// register, tracks the peer soft-vote word, waits for the PLL status and
// reports timeouts.
// Assumes: clients 0..N_DIRECT-1 are plain voters, N_DIRECT and N_DIRECT+1
// are the active-only and sleep-active peers, and N_DIRECT+2 is the sleep
// channel. Enable bits: plain voters, then the shared peer bit, then the
// sleep bit.
module pll_vote_hub #(
    parameter int N_DIRECT  = 3,
    parameter int US_CYCLES = 8,
    parameter int MAX_POLLS = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_DIRECT+1:0]   boot_en,
    input  logic [N_DIRECT+2:0]   req,
    input  logic [N_DIRECT+2:0]   req_on,
    input  logic                  pll_running,
    output logic [N_DIRECT+1:0]   pll_en,
    output logic [1:0]            peer_votes,
    output logic [N_DIRECT+2:0]   ack,
    output logic [N_DIRECT+2:0]   err
);
    import pll_vote_pkg::*;

    localparam int NCLI      = N_DIRECT + 3;
    localparam int EN_W      = N_DIRECT + 2;
    localparam int IDX_W     = $clog2(NCLI);
    localparam int PEER_BIT  = N_DIRECT;
    localparam int SLEEP_BIT = N_DIRECT + 1;
    localparam logic [IDX_W-1:0] PEER_B_IDX = IDX_W'(N_DIRECT + 1);

    logic [NCLI-1:0]  pending, want_on, clr;
    logic             any;
    logic [IDX_W-1:0] gidx;
    logic             tmr_start, tmr_run, expired;

    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] cur_q, cur_d;
    logic [EN_W-1:0]  en_q, en_d;
    logic [1:0]       soft_q, soft_d;
    logic [NCLI-1:0]  ack_q, ack_d, err_q, err_d;
    client_kind_t     gkind, ckind;
    logic             gpeer_b, cpeer_b;

    pll_vote_intake #(.NCLI(NCLI)) u_intake (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .req_on  (req_on),
        .clr     (clr),
        .pending (pending),
        .want_on (want_on)
    );

    pll_vote_arb #(.NCLI(NCLI), .IDX_W(IDX_W)) u_arb (
        .pending   (pending),
        .any       (any),
        .grant_idx (gidx)
    );

    pll_vote_timer #(.US_CYCLES(US_CYCLES), .MAX_POLLS(MAX_POLLS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tmr_start),
        .run     (tmr_run),
        .expired (expired)
    );

    // Classify the granted client and the client being waited on.
    always_comb begin
        gkind   = kind_of(int'(gidx), N_DIRECT);
        ckind   = kind_of(int'(cur_q), N_DIRECT);
        gpeer_b = (gidx == PEER_B_IDX);
        cpeer_b = (cur_q == PEER_B_IDX);
        tmr_run = (state_q == SEQ_WAIT);
    end

    // Sequencer next state: one request is served at a time.
    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        en_d      = en_q;
        soft_d    = soft_q;
        ack_d     = '0;
        err_d     = '0;
        clr       = '0;
        tmr_start = 1'b0;
        case (state_q)
            SEQ_IDLE: begin
                if (any) begin
                    cur_d = gidx;
                    case (gkind)
                        CK_DIRECT: begin
                            en_d[gidx] = want_on[gidx];
                            if (want_on[gidx]) begin
                                state_d   = SEQ_WAIT;
                                tmr_start = 1'b1;
                            end else begin
                                ack_d[gidx] = 1'b1;
                                clr[gidx]   = 1'b1;
                            end
                        end
                        CK_PEER: begin
                            if (want_on[gidx]) begin
                                if (soft_q == 2'b00) begin
                                    en_d[PEER_BIT] = 1'b1;
                                    state_d        = SEQ_WAIT;
                                    tmr_start      = 1'b1;
                                end else begin
                                    soft_d[gpeer_b] = 1'b1;
                                    ack_d[gidx]     = 1'b1;
                                    clr[gidx]       = 1'b1;
                                end
                            end else begin
                                soft_d[gpeer_b] = 1'b0;
                                if (!soft_q[~gpeer_b])
                                    en_d[PEER_BIT] = 1'b0;
                                ack_d[gidx] = 1'b1;
                                clr[gidx]   = 1'b1;
                            end
                        end
                        default: begin
                            en_d[SLEEP_BIT] = ~want_on[gidx];
                            ack_d[gidx]     = 1'b1;
                            clr[gidx]       = 1'b1;
                        end
                    endcase
                end
            end
            SEQ_WAIT: begin
                if (pll_running) begin
                    ack_d[cur_q] = 1'b1;
                    clr[cur_q]   = 1'b1;
                    if (ckind == CK_PEER)
                        soft_d[cpeer_b] = 1'b1;
                    state_d = SEQ_IDLE;
                end else if (expired) begin
                    ack_d[cur_q] = 1'b1;
                    err_d[cur_q] = 1'b1;
                    clr[cur_q]   = 1'b1;
                    state_d      = SEQ_IDLE;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Sequencer registers; reset takes over the start-up vote image.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            cur_q   <= '0;
            en_q    <= boot_en;
            soft_q  <= {2{boot_en[PEER_BIT]}};
            ack_q   <= '0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            en_q    <= en_d;
            soft_q  <= soft_d;
            ack_q   <= ack_d;
            err_q   <= err_d;
        end
    end

    // Drive the outputs from their registers.
    always_comb begin
        pll_en     = en_q;
        peer_votes = soft_q;
        ack        = ack_q;
        err        = err_q;
    end

endmodule

// File: rtl/pll_vote_hub_chk.sv
// Property checker for pll_vote_hub, attached with bind.
// Assumes: only the top-level ports are observed.
module pll_vote_hub_chk #(
    parameter int N_DIRECT = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_DIRECT+1:0] pll_en,
    input logic [1:0]          peer_votes,
    input logic [N_DIRECT+2:0] ack,
    input logic [N_DIRECT+2:0] err
);

    localparam int PEER_BIT  = N_DIRECT;
    localparam int SLEEP_BIT = N_DIRECT + 1;
    localparam int SLEEP_CLI = N_DIRECT + 2;

    // R10
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));

    // R10
    err_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err & ~ack) == '0);

    // R9
    one_bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pll_en ^ $past(pll_en)) <= 1);

    // R8
    sleep_bit_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pll_en[SLEEP_BIT]) |-> ack[SLEEP_CLI]);

    // R7
    peer_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_en[PEER_BIT]) |-> (peer_votes == 2'b00));

    // R6
    peer_backing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_votes != 2'b00) |-> pll_en[PEER_BIT]);

    genvar gi;
    generate
        for (gi = 0; gi < N_DIRECT; gi++) begin : g_direct
            // R4
            timeout_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
                err[gi] |-> pll_en[gi]);
        end
    endgenerate

endmodule

bind pll_vote_hub pll_vote_hub_chk #(.N_DIRECT(N_DIRECT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pll_en     (pll_en),
    .peer_votes (peer_votes),
    .ack        (ack),
    .err        (err)
);

// File: tb/sim_pll_vote_hub.sv
// Self-checking bench: sweeps over a small configuration of pll_vote_hub.
module sim_pll_vote_hub;

    localparam int CLK_PERIOD = 10;
    localparam int ND   = 3;
    localparam int USC  = 2;
    localparam int MAXP = 6;
    localparam int NCLI = ND + 3;
    localparam int EN_W = ND + 2;
    localparam int PB   = ND;
    localparam int SB   = ND + 1;
    localparam int SLC  = ND + 2;
    localparam int TO_LAT = 1 + MAXP * USC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [EN_W-1:0] boot_en = '0;
    logic [NCLI-1:0] req = '0;
    logic [NCLI-1:0] req_on = '0;
    logic            pll_running = 1'b0;
    logic [EN_W-1:0] pll_en;
    logic [1:0]      peer_votes;
    logic [NCLI-1:0] ack, err;

    int checks = 0;
    int errors = 0;
    logic [EN_W-1:0] m_en;
    logic [1:0]      m_soft;

    pll_vote_hub #(.N_DIRECT(ND), .US_CYCLES(USC), .MAX_POLLS(MAXP)) u0 (
        .clk(clk), .rst_n(rst_n), .boot_en(boot_en), .req(req), .req_on(req_on),
        .pll_running(pll_running), .pll_en(pll_en), .peer_votes(peer_votes),
        .ack(ack), .err(err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string rq, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Reset with a start-up image and check the takeover (R1).
    task automatic do_reset(input logic [EN_W-1:0] b);
        @(negedge clk);
        rst_n = 1'b0; boot_en = b;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_en = b; m_soft = {2{b[PB]}};
        check(pll_en == m_en, "R1 enable image", pll_en, m_en);
        check(peer_votes == m_soft, "R1 peer word", peer_votes, m_soft);
        check(ack == '0, "R1 no ack", ack, 0);
    endtask

    // One request from client c; model, latency, error and state checks.
    task automatic op(input int c, input bit on);
        int exp_lat; bit exp_err; int lat; string rq;
        exp_err = 1'b0;
        if (c < ND) begin
            if (on) begin
                m_en[c] = 1'b1;
                exp_lat = pll_running ? 2 : TO_LAT; exp_err = !pll_running;
                rq = pll_running ? "R3 vote" : "R4 timeout";
            end else begin
                m_en[c] = 1'b0; exp_lat = 1; rq = "R5 withdraw";
            end
        end else if (c < SLC) begin
            if (on) begin
                if (m_soft == 2'b00) begin
                    m_en[PB] = 1'b1;
                    if (pll_running) m_soft[c-ND] = 1'b1;
                    exp_lat = pll_running ? 2 : TO_LAT; exp_err = !pll_running;
                end else begin
                    m_soft[c-ND] = 1'b1; exp_lat = 1;
                end
                rq = "R6 peer vote";
            end else begin
                m_soft[c-ND] = 1'b0;
                if (m_soft == 2'b00) m_en[PB] = 1'b0;
                exp_lat = 1; rq = "R7 peer withdraw";
            end
        end else begin
            m_en[SB] = !on; exp_lat = 1; rq = "R8 sleep";
        end
        @(negedge clk);
        req[c] = 1'b1; req_on[c] = on;
        @(negedge clk);
        req = '0;
        lat = 0;
        for (int k = 0; k < 100; k++) begin
            @(negedge clk);
            lat++;
            if (ack[c]) break;
        end
        check(ack[c] == 1'b1 && lat == exp_lat, {rq, " latency"}, lat, exp_lat);
        check(err[c] == exp_err, {rq, " error flag"}, err[c], exp_err);
        check(pll_en == m_en, {rq, " R2 enable bits"}, pll_en, m_en);
        check(peer_votes == m_soft, {rq, " peer word"}, peer_votes, m_soft);
        @(negedge clk);
        check(ack == '0, "R10 single-cycle ack", ack, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        do_reset('0);
        pll_running = 1'b1;

        // R2 R3 R5: every subset of plain voters, then release from the top.
        for (int mask = 0; mask < (1 << ND); mask++) begin
            for (int i = 0; i < ND; i++) if (mask[i]) op(i, 1'b1);
            for (int i = ND - 1; i >= 0; i--) if (mask[i]) op(i, 1'b0);
        end

        // R5: withdrawal is immediate even with the status low.
        op(0, 1'b1);
        pll_running = 1'b0;
        op(0, 1'b0);

        // R4: timeout leaves the bit set.
        op(1, 1'b1);
        op(1, 1'b0);
        pll_running = 1'b1;

        // R6 R7: all arrival and departure orders of the peer pair.
        for (int fa = 0; fa < 2; fa++) begin
            for (int fd = 0; fd < 2; fd++) begin
                op(ND + fa, 1'b1);
                op(ND + 1 - fa, 1'b1);
                op(ND + fa, 1'b1);
                op(ND + fd, 1'b0);
                op(ND + 1 - fd, 1'b0);
            end
        end

        // R6: failed hardware vote keeps the soft word clear; next peer re-votes.
        pll_running = 1'b0;
        op(ND, 1'b1);
        pll_running = 1'b1;
        op(ND + 1, 1'b1);
        op(ND + 1, 1'b0);

        // R8: sleep channel in both status levels.
        for (int r = 0; r < 2; r++) begin
            pll_running = r[0];
            op(SLC, 1'b1);
            op(SLC, 1'b0);
        end
        pll_running = 1'b1;

        // R1 R7: every start-up image, then both peers withdraw.
        for (int b = 0; b < (1 << EN_W); b++) begin
            do_reset(EN_W'(b));
            op(ND, 1'b0);
            op(ND + 1, 1'b0);
        end

        // R9: simultaneous requests, served lowest index first.
        do_reset('0);
        begin
            int order[$];
            int exp_order[4];
            exp_order = '{0, 2, ND, SLC};
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                req[exp_order[i]] = 1'b1; req_on[exp_order[i]] = 1'b1;
            end
            @(negedge clk);
            req = '0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                check($countones(ack) <= 1, "R10 one ack per cycle", ack, 0);
                for (int i = 0; i < NCLI; i++) if (ack[i]) order.push_back(i);
            end
            check(order.size() == 4, "R9 ack count", order.size(), 4);
            for (int i = 0; i < 4; i++)
                if (i < order.size())
                    check(order[i] == exp_order[i], "R9 service order", order[i], exp_order[i]);
            m_en = '0; m_en[0] = 1'b1; m_en[2] = 1'b1; m_en[PB] = 1'b1;
            check(pll_en == m_en, "R9 no lost vote", pll_en, m_en);
            check(peer_votes == 2'b01, "R9 peer word", peer_votes, 1);
        end

        finish_run();
    end

endmodule